// File: doc/BRIEF.md
# Two-bit burst address sequencer

This block produces the address presented to a synchronous SRAM array during a burst. A start strobe captures the whole external address into a register. From then on the upper bits stay fixed while the two lowest bits walk through a four-beat sequence. A static order input selects that sequence: interleaved, where each beat is the start value XOR the beat number, or linear, which counts up by one and wraps modulo four.

Each cycle the active-low advance input either steps to the next beat or holds the current address. Two independent start strobes exist, one for each of two bus masters, and either one starts a burst. Decoding of read, write and deselect cycles, and the array itself, belong to the surrounding logic.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `addr_o` is all zeros.
- R2: With `mode_i` = 1 (interleaved), the k-th beat of a burst has low bits equal to start XOR k. A start of 01 gives 01,00,11,10 and a start of 10 gives 10,11,00,01.
- R3: With `mode_i` = 0 (linear), each step sets the low bits to the previous low bits plus one, modulo four.
- R4: A high level on either `start_a_i` or `start_b_i` at a clock edge loads `ext_addr_i` whole into `addr_o`, which is visible after that edge.
- R5: With no start and `adv_n_i` = 1, `addr_o` keeps its value.
- R6: Between starts, `addr_o[AW-1:2]` keeps the value captured at the last start, whatever advance and mode do.
- R7: After the fourth beat, a further step returns to the start address, in both orders.
- R8: A start in the same cycle as `adv_n_i` = 0 loads the external address and performs no step.
- R9: A change of `mode_i` with no step leaves `addr_o` unchanged. The new order applies from the next step onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_a_i | input | 1 | Burst start strobe from the first master |
| start_b_i | input | 1 | Burst start strobe from the second master |
| adv_n_i | input | 1 | 0 steps to the next beat, 1 holds |
| mode_i | input | 1 | 1 selects interleaved order, 0 selects linear |
| ext_addr_i | input | AW | External address captured on a start |
| addr_o | output | AW | Current array address |

## Verification
A start and an advance can both be active in the same cycle. The bench drives them together deliberately, with both strobes and with different low start values. It also holds them together for many cycles in a random phase. The result is judged against a behavioural model in which a start always wins: the captured address must appear unchanged, with no step applied. A second overlap is a mode change coinciding with a hold or a step. This is judged by requiring no movement on the hold and the newly selected order on the step.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int unsigned BEAT_W = 2;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;

  // next low bits: interleave uses base ^ next index, linear uses current + 1
  function automatic logic [BEAT_W-1:0] next_beat(
    input burst_order_e      order,
    input logic [BEAT_W-1:0] base,
    input logic [BEAT_W-1:0] next_idx,
    input logic [BEAT_W-1:0] cur
  );
    logic [BEAT_W-1:0] r;
    if (order == ORDER_INTERLEAVE) r = base ^ next_idx;
    else                           r = cur + {{(BEAT_W-1){1'b0}}, 1'b1};
    return r;
  endfunction

endpackage

// File: rtl/bas_rst_sync.sv
module bas_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/bas_upper_reg.sv
module bas_upper_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (load_i) q_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              step_i,
  input  burst_order_e      order_i,
  input  logic [BEAT_W-1:0] start_lo_i,
  output logic [BEAT_W-1:0] lo_o
);
  logic [BEAT_W-1:0] base_d, base_q;
  logic [BEAT_W-1:0] idx_d,  idx_q;
  logic [BEAT_W-1:0] lo_d,   lo_q;
  logic [BEAT_W-1:0] idx_inc;

  assign idx_inc = idx_q + {{(BEAT_W-1){1'b0}}, 1'b1};

  always_comb begin
    base_d = base_q;
    idx_d  = idx_q;
    lo_d   = lo_q;
    if (start_i) begin
      base_d = start_lo_i;
      idx_d  = '0;
      lo_d   = start_lo_i;
    end else if (step_i) begin
      idx_d = idx_inc;
      lo_d  = next_beat(order_i, base_q, idx_inc, lo_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
      lo_q   <= '0;
    end else begin
      base_q <= base_d;
      idx_q  <= idx_d;
      lo_q   <= lo_d;
    end
  end

  assign lo_o = lo_q;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_a_i,
  input  logic          start_b_i,
  input  logic          adv_n_i,
  input  logic          mode_i,
  input  logic [AW-1:0] ext_addr_i,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned UW = AW - BEAT_W;

  logic          rst_n_s;
  logic          start;
  logic          step;
  burst_order_e  order;
  logic [UW-1:0] upper;
  logic [BEAT_W-1:0] lo;

  assign start = start_a_i | start_b_i;
  assign step  = ~adv_n_i;
  assign order = burst_order_e'(mode_i);

  bas_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  bas_upper_reg #(.W(UW)) u_upper (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load_i (start),
    .d_i    (ext_addr_i[AW-1:BEAT_W]),
    .q_o    (upper)
  );

  bas_beat_ctr u_beat (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start_i    (start),
    .step_i     (step),
    .order_i    (order),
    .start_lo_i (ext_addr_i[BEAT_W-1:0]),
    .lo_o       (lo)
  );

  assign addr_o = {upper, lo};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_a_i,
  input logic          start_b_i,
  input logic          adv_n_i,
  input logic          mode_i,
  input logic [AW-1:0] ext_addr_i,
  input logic [AW-1:0] addr_o
);
  logic start;
  assign start = start_a_i | start_b_i;

  // R4, R8: a start loads the external address, advance ignored
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    (start && $past(rst_n)) |=> (addr_o == $past(ext_addr_i)));

  // R6: upper bits keep their value without a start
  a_r6_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(addr_o[AW-1:2]));

  // R5: hold keeps the whole address
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && adv_n_i) |=> $stable(addr_o));

  // R3: a linear step adds one to the low bits
  a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !adv_n_i && !mode_i) |=> (addr_o[1:0] == $past(addr_o[1:0]) + 2'd1));

  // R2: every interleaved step flips bit 0
  a_r2_interleave_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !adv_n_i && mode_i) |=> (addr_o[0] != $past(addr_o[0])));

  // R1: output is zero while reset is asserted
  always @(negedge clk) if (!rst_n) a_r1_reset_zero: assert (addr_o == '0);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_a_i  (start_a_i),
  .start_b_i  (start_b_i),
  .adv_n_i    (adv_n_i),
  .mode_i     (mode_i),
  .ext_addr_i (ext_addr_i),
  .addr_o     (addr_o)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_a_i = 1'b0, start_b_i = 1'b0;
  logic          adv_n_i = 1'b1, mode_i = 1'b1;
  logic [AW-1:0] ext_addr_i = '0;
  logic [AW-1:0] addr_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_up = 0, m_base = 0, m_idx = 0, m_lo = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start_a_i(start_a_i), .start_b_i(start_b_i),
    .adv_n_i(adv_n_i), .mode_i(mode_i), .ext_addr_i(ext_addr_i), .addr_o(addr_o)
  );

  function automatic int expected();
    return m_up * 4 + m_lo;
  endfunction

  task automatic check(input string tag, input int exp);
    checks++;
    if (int'(addr_o) != exp) begin
      errors++;
      $display("FAIL %s: addr_o=%05h expected=%05h", tag, addr_o, exp);
    end
  endtask

  // one cycle: drive, clock, update model, compare
  task automatic cyc(input bit sa, input bit sb, input bit advn, input bit md,
                     input int addr, input string tag);
    int up_before;
    start_a_i = sa; start_b_i = sb; adv_n_i = advn; mode_i = md;
    ext_addr_i = AW'(addr);
    up_before = m_up;
    @(posedge clk);
    if (sa || sb) begin
      m_up = (addr >> 2) & ((1 << (AW-2)) - 1);
      m_base = addr & 3; m_idx = 0; m_lo = m_base;
    end else if (!advn) begin
      m_idx = (m_idx + 1) % 4;
      m_lo  = md ? (m_base ^ m_idx) : ((m_lo + 1) % 4);
    end
    #1;
    check(tag, expected());
    if (!(sa || sb)) begin
      checks++;
      if (int'(addr_o[AW-1:2]) != up_before) begin
        errors++;
        $display("FAIL R6: upper=%05h expected=%05h", addr_o[AW-1:2], up_before);
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: expired expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, 'h3ffff, "R1 after release");

    // R2 interleaved from 01, with wrap R7
    cyc(1, 0, 1, 1, 'h2a5d1, "R4 load via A");
    cyc(0, 0, 0, 1, 0, "R2 beat1 (00)");
    check("R2 low bits", (m_up*4) | 0);
    cyc(0, 0, 0, 1, 0, "R2 beat2 (11)");
    check("R2 low bits", (m_up*4) | 3);
    cyc(0, 0, 0, 1, 0, "R2 beat3 (10)");
    check("R2 low bits", (m_up*4) | 2);
    cyc(0, 0, 0, 1, 0, "R7 wrap interleave");
    check("R7 back to start", 'h2a5d1);

    // interleaved from 10
    cyc(0, 1, 1, 1, 'h01232, "R4 load via B");
    cyc(0, 0, 0, 1, 0, "R2 from 10 beat1 (11)");
    check("R2 low bits", 'h01233);
    cyc(0, 0, 0, 1, 0, "R2 from 10 beat2 (00)");
    check("R2 low bits", 'h01230);
    cyc(0, 0, 0, 1, 0, "R2 from 10 beat3 (01)");
    check("R2 low bits", 'h01231);

    // linear from 10 with hold R5 and wrap R7
    cyc(0, 1, 1, 0, 'h3c0f6, "R4 load via B");
    cyc(0, 0, 0, 0, 0, "R3 step (11)");
    check("R3 low bits", 'h3c0f7);
    cyc(0, 0, 1, 0, 'h12345, "R5 hold");
    check("R5 unchanged", 'h3c0f7);
    cyc(0, 0, 0, 0, 0, "R3 step (00)");
    check("R3 wraps modulo four", 'h3c0f4);
    cyc(0, 0, 0, 0, 0, "R3 step (01)");
    cyc(0, 0, 0, 0, 0, "R7 wrap linear");
    check("R7 back to start", 'h3c0f6);

    // R8: start together with advance
    cyc(1, 0, 0, 1, 'h15553, "R8 start wins over advance");
    check("R8 no step", 'h15553);
    cyc(1, 1, 0, 0, 'h0aaa8, "R8 both strobes with advance");
    check("R8 no step", 'h0aaa8);

    // R9: mode change mid-burst
    cyc(1, 0, 1, 1, 'h00011, "R4 load");
    cyc(0, 0, 0, 1, 0, "R2 step to 00");
    cyc(0, 0, 1, 0, 0, "R9 mode change while holding");
    check("R9 no movement", 'h00010);
    cyc(0, 0, 0, 0, 0, "R9 linear after switch");
    check("R9 new order", 'h00011);

    // random phase, overlaps included
    for (int i = 0; i < 400; i++) begin
      bit sa, sb, an, md;
      sa = ($urandom % 6) == 0;
      sb = ($urandom % 7) == 0;
      an = $urandom % 2;
      md = $urandom % 2;
      cyc(sa, sb, an, md, int'($urandom % (1 << AW)),
          (sa || sb) ? "R4/R8 random start" : (an ? "R5 random hold" :
          (md ? "R2 random step" : "R3 random step")));
    end

    // R1: reset mid-burst clears the address
    rst_n = 1'b0;
    #1;
    m_up = 0; m_lo = 0; m_base = 0; m_idx = 0;
    check("R1 async clear", 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule